// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slow output clock from a fast reference clock. A single integer divider can only reach rates of the form reference/N. A low-power timekeeping clock near 32.768 kHz rarely falls on such a value. The block therefore alternates between two integer divide ratios. It runs a programmable number of output periods at the first ratio, then a programmable number at the second, and repeats that pattern. The long-run average rate lands between the two integer rates.

A mode input selects dual operation or plain single-ratio division. Four configuration fields (two ratios and two repeat counts) arrive on plain inputs, each encoded as the wanted value minus one. The block captures them into a shadow copy when it starts and again only at safe boundaries, so a mid-pattern reprogram never produces a short pulse. Besides the divided clock, the block drives a one-cycle strobe at the start of every output period. Logic in the reference domain can use it to time or count output periods.

Top module: `dualmod_clkdiv`

## Requirements
- R1: With `cfg_dual` = 0 in the captured configuration, every output period lasts `cfg_n1`+1 reference cycles, and the second ratio and both repeat counts have no effect.
- R2: With `cfg_dual` = 1, the output runs `cfg_m1`+1 periods of `cfg_n1`+1 cycles, then `cfg_m2`+1 periods of `cfg_n2`+1 cycles, and repeats this pattern for as long as the block stays enabled.
- R3: In dual mode, one full pattern contains exactly (M1+M2) strobes in (N1·M1 + N2·M2) reference cycles, where each N and M is its field value plus one.
- R4: A field value of 0 means a ratio or repeat count of 1. A ratio of 1 holds the output high with a strobe every cycle. A count of 1 gives a single period in that phase.
- R5: In a period of N cycles the output is high for the first floor(N/2) cycles and low for the rest, except N = 1, where it is high for the whole cycle.
- R6: Configuration is captured on the clock edge where the block leaves the idle state. After that it is recaptured only on the last cycle of a complete pattern (dual) or of a period (single). Input changes at any other time have no effect on the output.
- R7: A synchronous active-low reset drives `clk_out` and `rise_stb` low. The first pattern after reset begins in the first-ratio phase.
- R8: While `en` is low, `clk_out` and `rise_stb` are low from the next edge on. After `en` is sampled high on one edge, the first period starts (output high, strobe high) on the following edge.
- R9: `rise_stb` is high for exactly the first cycle of each output period, so every low-to-high transition of `clk_out` coincides with a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Divider enable; low holds the output low and counters cleared |
| cfg_dual | input | 1 | 1 selects alternating two-ratio operation, 0 selects the first ratio only |
| cfg_n1 | input | NW | First divide ratio minus one |
| cfg_m1 | input | MW | Periods spent at the first ratio, minus one |
| cfg_n2 | input | NW | Second divide ratio minus one |
| cfg_m2 | input | MW | Periods spent at the second ratio, minus one |
| clk_out | output | 1 | Divided output clock (registered) |
| rise_stb | output | 1 | One-cycle pulse on the first cycle of each output period |

## Verification
The bench builds the divider with a 4-bit ratio field and a 3-bit repeat field. The largest ratio (16) and the largest repeat count (8) are then short enough to sweep a full maximum-length pattern in a few hundred cycles, alongside ratio 1 and count 1 at the other end. At these widths, mid-pattern reprogramming, mode flips and disable or reset in the middle of a period can all be compared cycle by cycle against a queue-based model. The model regenerates each pattern from the configuration it sampled at the pattern boundary.

// File: rtl/dd_pkg.sv
// Shared types for the dual-modulus divider.
// Assumes: nothing beyond IEEE 1800-2017.
package dd_pkg;

    // Which of the two divide ratios the current output period uses.
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } dd_phase_e;

endpackage

// File: rtl/dd_cfg_hold.sv
// Shadow copy of the divider configuration.
// Captures the live inputs whenever load is high and holds them otherwise,
// so the counters always see a coherent set of fields.
// Assumes: load is computed in the same clock domain.
module dd_cfg_hold #(
    parameter int NW = 8,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          d_dual,
    input  logic [NW-1:0] d_n1,
    input  logic [MW-1:0] d_m1,
    input  logic [NW-1:0] d_n2,
    input  logic [MW-1:0] d_m2,
    output logic          q_dual,
    output logic [NW-1:0] q_n1,
    output logic [MW-1:0] q_m1,
    output logic [NW-1:0] q_n2,
    output logic [MW-1:0] q_m2
);

    // Capture or hold the configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_dual <= 1'b0;
            q_n1   <= '0;
            q_m1   <= '0;
            q_n2   <= '0;
            q_m2   <= '0;
        end else if (load) begin
            q_dual <= d_dual;
            q_n1   <= d_n1;
            q_m1   <= d_m1;
            q_n2   <= d_n2;
            q_m2   <= d_m2;
        end
    end

    // Shadow must not move between capture points.
    assert_frozen_between_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({q_dual, q_n1, q_m1, q_n2, q_m2}));

endmodule

// File: rtl/dd_period_cnt.sv
// Period counter and output stage.
// Counts reference cycles within one output period of ratio_m1+1 cycles,
// drives the registered output high for the first half of the period and
// pulses the strobe on its first cycle. Outputs lag the count by one edge.
// Assumes: ratio_m1 only changes on the edge that ends a period.
module dd_period_cnt #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [NW-1:0] ratio_m1,
    output logic          period_end,
    output logic          clk_out,
    output logic          rise_stb
);

    logic [NW-1:0] cyc;
    logic [NW:0]   n_full;
    logic [NW:0]   hi_len;

    // Length of the high part of the current period.
    always_comb begin
        n_full = {1'b0, ratio_m1} + 1'b1;
        hi_len = (ratio_m1 == '0) ? (NW+1)'(1) : (n_full >> 1);
    end

    assign period_end = run && (cyc == ratio_m1);

    // Advance the cycle index and register the output shape.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cyc      <= '0;
            clk_out  <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            clk_out  <= ({1'b0, cyc} < hi_len);
            rise_stb <= (cyc == '0);
            cyc      <= period_end ? '0 : cyc + 1'b1;
        end
    end

    // A strobe always falls in the high part of a period.
    assert_strobe_in_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> clk_out);

    // Every rising output edge is marked by the strobe.
    assert_rise_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out && !$past(clk_out)) |-> rise_stb);

endmodule

// File: rtl/dd_repeat_seq.sv
// Repeat counter and phase sequencer.
// Counts completed periods in the current phase and swaps to the other
// ratio after the programmed number; flags the edge where new
// configuration may be captured.
// Assumes: dual, m1 and m2 come from the shadow copy.
module dd_repeat_seq
    import dd_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          dual,
    input  logic          period_end,
    input  logic [MW-1:0] m1,
    input  logic [MW-1:0] m2,
    output dd_phase_e     phase,
    output logic          reload
);

    logic [MW-1:0] rep;
    logic          last_rep;

    // Detect the last period of the current phase and the pattern end.
    always_comb begin
        last_rep = (rep == ((phase == PH_A) ? m1 : m2));
        reload   = period_end && (!dual || ((phase == PH_B) && last_rep));
    end

    // Step the repeat count and swap phase after the last repeat.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= PH_A;
            rep   <= '0;
        end else if (period_end) begin
            if (!dual) begin
                phase <= PH_A;
                rep   <= '0;
            end else if (last_rep) begin
                phase <= (phase == PH_A) ? PH_B : PH_A;
                rep   <= '0;
            end else begin
                rep   <= rep + 1'b1;
            end
        end
    end

    // Single mode never leaves the first-ratio phase.
    assert_single_phase_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !dual) |-> (phase == PH_A));

    // Phase changes only at a period boundary or when stopped.
    assert_phase_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |-> ($past(period_end) || !$past(run)));

endmodule

// File: rtl/dualmod_clkdiv.sv
// Dual-modulus fractional clock divider, top level.
// Alternates two integer divide ratios, each for a programmed number of
// output periods, to reach an average rate between them.
// Assumes: configuration inputs are synchronous to clk.
module dualmod_clkdiv
    import dd_pkg::*;
#(
    parameter int NW = 8,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cfg_dual,
    input  logic [NW-1:0] cfg_n1,
    input  logic [MW-1:0] cfg_m1,
    input  logic [NW-1:0] cfg_n2,
    input  logic [MW-1:0] cfg_m2,
    output logic          clk_out,
    output logic          rise_stb
);

    logic          active;
    logic          run;
    logic          load;
    logic          reload;
    logic          period_end;
    dd_phase_e     phase;
    logic          s_dual;
    logic [NW-1:0] s_n1;
    logic [MW-1:0] s_m1;
    logic [NW-1:0] s_n2;
    logic [MW-1:0] s_m2;
    logic [NW-1:0] ratio_cur;

    // Remember that the divider was enabled on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= en;
    end

    assign run       = active && en;
    assign load      = !run || reload;
    assign ratio_cur = (phase == PH_A) ? s_n1 : s_n2;

    dd_cfg_hold #(.NW(NW), .MW(MW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .d_dual (cfg_dual),
        .d_n1   (cfg_n1),
        .d_m1   (cfg_m1),
        .d_n2   (cfg_n2),
        .d_m2   (cfg_m2),
        .q_dual (s_dual),
        .q_n1   (s_n1),
        .q_m1   (s_m1),
        .q_n2   (s_n2),
        .q_m2   (s_m2)
    );

    dd_repeat_seq #(.MW(MW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dual       (s_dual),
        .period_end (period_end),
        .m1         (s_m1),
        .m2         (s_m2),
        .phase      (phase),
        .reload     (reload)
    );

    dd_period_cnt #(.NW(NW)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .ratio_m1   (ratio_cur),
        .period_end (period_end),
        .clk_out    (clk_out),
        .rise_stb   (rise_stb)
    );

    // Disabled divider is silent from the next edge.
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!clk_out && !rise_stb));

    // Leaving reset or idle always starts in the first-ratio phase.
    assert_start_phase_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase == PH_A));

endmodule

// File: tb/dualmod_clkdiv_tb.sv
// Bench: queue-based behavioural model compared on every clock.
module dualmod_clkdiv_tb;

    localparam int NW = 4;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          cfg_dual = 1'b0;
    logic [NW-1:0] cfg_n1 = '0;
    logic [MW-1:0] cfg_m1 = '0;
    logic [NW-1:0] cfg_n2 = '0;
    logic [MW-1:0] cfg_m2 = '0;
    logic          clk_out;
    logic          rise_stb;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_tag = "R7 reset";

    bit    q_out[$];
    bit    q_stb[$];
    bit    started = 0;
    bit    armed   = 0;
    logic  exp_out = 1'b0;
    logic  exp_stb = 1'b0;

    always #4 clk = ~clk;

    dualmod_clkdiv #(.NW(NW), .MW(MW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cfg_dual (cfg_dual),
        .cfg_n1   (cfg_n1),
        .cfg_m1   (cfg_m1),
        .cfg_n2   (cfg_n2),
        .cfg_m2   (cfg_m2),
        .clk_out  (clk_out),
        .rise_stb (rise_stb)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic push_period(input int n);
        int h;
        h = (n == 1) ? 1 : n / 2;
        for (int i = 0; i < n; i++) begin
            q_out.push_back(i < h);
            q_stb.push_back(i == 0);
        end
    endtask

    // Builds one whole pattern from the inputs seen at a capture edge.
    task automatic push_pattern();
        if (!cfg_dual) begin
            push_period(int'(cfg_n1) + 1);
        end else begin
            for (int k = 0; k <= int'(cfg_m1); k++) push_period(int'(cfg_n1) + 1);
            for (int k = 0; k <= int'(cfg_m2); k++) push_period(int'(cfg_n2) + 1);
        end
    endtask

    // Reference model: advances on each edge using pre-edge inputs.
    always @(posedge clk) begin
        cycles++;
        armed = 1;
        if (!rst_n || !en) begin
            q_out.delete();
            q_stb.delete();
            started = 0;
            exp_out = 1'b0;
            exp_stb = 1'b0;
        end else if (!started) begin
            started = 1;
            exp_out = 1'b0;
            exp_stb = 1'b0;
            push_pattern();
        end else begin
            exp_out = q_out.pop_front();
            exp_stb = q_stb.pop_front();
            if (q_out.size() == 0) push_pattern();
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            chk({cur_tag, " clk_out"}, clk_out, exp_out);
            chk({cur_tag, " rise_stb"}, rise_stb, exp_stb);
        end
    end

    // Watchdog.
    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic d, input int n1, input int m1, input int n2, input int m2);
        cfg_dual = d;
        cfg_n1   = NW'(n1);
        cfg_m1   = MW'(m1);
        cfg_n2   = NW'(n2);
        cfg_m2   = MW'(m2);
    endtask

    initial begin
        int strobes;
        @(negedge clk);
        wait_cyc(3);
        // R7: reset state
        chk("R7 reset clk_out", clk_out, 1'b0);
        chk("R7 reset rise_stb", rise_stb, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1, R5: single mode, ratio 5; second ratio set differently
        cur_tag = "R1 R5 single n5";
        set_cfg(1'b0, 4, 5, 9, 3);
        en = 1'b1;
        @(negedge clk);
        // R8: one edge after enable sampled, still idle
        chk("R8 first edge clk_out", clk_out, 1'b0);
        @(negedge clk);
        chk("R8 period start clk_out", clk_out, 1'b1);
        chk("R8 period start rise_stb", rise_stb, 1'b1);
        wait_cyc(40);

        // R4: ratio 1 holds output high
        cur_tag = "R4 single ratio1";
        set_cfg(1'b0, 0, 0, 0, 0);
        wait_cyc(20);
        chk("R4 ratio1 clk_out", clk_out, 1'b1);
        chk("R4 ratio1 rise_stb", rise_stb, 1'b1);

        // R5: even and odd ratios for the duty split
        cur_tag = "R5 single n2";
        set_cfg(1'b0, 1, 0, 0, 0);
        wait_cyc(16);
        cur_tag = "R5 single n8";
        set_cfg(1'b0, 7, 0, 0, 0);
        wait_cyc(40);

        // R2, R3: dual mode, N1=4 M1=3 N2=5 M2=2; restart for clean pattern start
        cur_tag = "R2 dual";
        en = 1'b0;
        wait_cyc(3);
        chk("R8 disabled clk_out", clk_out, 1'b0);
        chk("R8 disabled rise_stb", rise_stb, 1'b0);
        set_cfg(1'b1, 3, 2, 4, 1);
        en = 1'b1;
        wait_cyc(2);
        // R3: strobes in three patterns of 22 cycles
        strobes = 0;
        for (int c = 0; c < 66; c++) begin
            if (rise_stb === 1'b1) strobes++;
            @(negedge clk);
        end
        n_tests++;
        if (strobes != 15) begin
            n_fail++;
            $display("FAIL R3 average: actual %0d strobes expected 15", strobes);
        end

        // R6: reprogram mid pattern, several times at odd offsets
        cur_tag = "R6 midpattern change";
        wait_cyc(7);
        set_cfg(1'b1, 6, 1, 2, 3);
        wait_cyc(5);
        set_cfg(1'b1, 2, 3, 7, 0);
        wait_cyc(90);
        set_cfg(1'b0, 5, 7, 7, 7);
        wait_cyc(3);
        set_cfg(1'b0, 2, 7, 7, 7);
        wait_cyc(30);
        set_cfg(1'b1, 1, 0, 3, 0);
        wait_cyc(40);

        // R4: counts of one in dual mode
        cur_tag = "R4 dual counts1";
        set_cfg(1'b1, 2, 0, 5, 0);
        wait_cyc(60);

        // Boundary: largest ratios and counts
        cur_tag = "R2 dual max";
        set_cfg(1'b1, 15, 7, 14, 7);
        wait_cyc(600);
        cur_tag = "R1 single max";
        set_cfg(1'b0, 15, 0, 0, 0);
        wait_cyc(300);

        // R8: disable mid period, then re-enable
        cur_tag = "R8 disable midperiod";
        set_cfg(1'b1, 5, 1, 3, 2);
        wait_cyc(13);
        en = 1'b0;
        wait_cyc(1);
        chk("R8 disabled midperiod clk_out", clk_out, 1'b0);
        wait_cyc(5);
        en = 1'b1;
        wait_cyc(50);

        // R7: reset mid run restarts in first ratio
        cur_tag = "R7 reset midrun";
        wait_cyc(9);
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R7 midrun reset clk_out", clk_out, 1'b0);
        rst_n = 1'b1;
        wait_cyc(80);

        // R9: strobe/edge relation checked by the model across a mix
        cur_tag = "R9 mixed";
        set_cfg(1'b1, 0, 2, 1, 2);
        wait_cyc(60);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule